// File: doc/BRIEF.md
# Split Instruction/Data L1 Request Dispatcher

This block sits between a processor's request queue and a cache controller that owns a split instruction cache and data cache. Each cycle it examines the request at the head of the queue and turns it into one controller event aimed at one line address. A request can become its own access event, or it can become a replacement event that frees space first.

A code fetch is steered to the instruction cache. Loads, stores and atomics are steered to the data cache. A line held in the cache the request does not target is evicted first, because no line may live in both caches at once. When the target cache misses and its set is full, the request instead becomes a replacement of the victim line that the cache supplies. Whenever a replacement is issued the request stays at the head of the queue, so it is dispatched again once the eviction is done. The decision is combinational from the inputs to the registered event outputs. The event is held under a valid/ready handshake until the controller takes it.

Top module: `l1_split_dispatch`

## Requirements
- R1: After reset, `evt_valid` is 0 and `req_ready` is 1.
- R2: Request type encoding is 0 = load, 1 = fetch, 2 = store, 3 = atomic. A fetch targets the instruction cache. Load, store and atomic target the data cache.
- R3: If the line is present in the non-target cache, the event is a replacement (code 3) for the request's own line address. This takes priority over every other outcome.
- R4: If the line is present in the target cache and absent from the other cache, the event is the request's own event at the request line address.
- R5: On a target miss with `space_avail`=1, the event is the request's own event at the request line address.
- R6: On a target miss with `space_avail`=0, the event is a replacement (code 3) at `victim_addr`.
- R7: Event codes are 0 = Load, 1 = Ifetch, 2 = Store, 3 = Replace. A load maps to Load, a fetch maps to Ifetch, and a store or an atomic maps to Store.
- R8: `req_pop` is 1 exactly when an accepted request produced a non-replacement event. A replacement leaves the request in the queue.
- R9: A request is accepted when `req_valid` and `req_ready` are both 1. Its event appears on the outputs in the next cycle.
- R10: While `evt_valid`=1 and `evt_ready`=0, `evt_code`, `evt_addr` and `evt_pop` hold their values and `req_ready` is 0. At most one event is issued per cycle.
- R11: An accepted request with a type code above 3 issues no event and raises `err_type` for one cycle. `req_type` is 3 bits wide so that such codes can be driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is at the head of the queue |
| req_ready | output | 1 | The dispatcher can take a request |
| req_type | input | 3 | Request type code |
| req_addr | input | ADDR_W | Line address of the request |
| icache_hit | input | 1 | Tag of `req_addr` is present in the instruction cache |
| dcache_hit | input | 1 | Tag of `req_addr` is present in the data cache |
| space_avail | input | 1 | The target cache set has a free way |
| victim_addr | input | ADDR_W | Victim line chosen in the target cache |
| evt_valid | output | 1 | An event is offered to the controller |
| evt_ready | input | 1 | The controller takes the event |
| evt_code | output | 2 | Event code |
| evt_addr | output | ADDR_W | Line address the event applies to |
| evt_pop | output | 1 | The request is consumed along with this event |
| req_pop | output | 1 | Pulse: remove the head request from the queue |
| err_type | output | 1 | Pulse: an accepted request had an invalid type |

## Verification
Every result belongs to the cycle after the acceptance edge. The event fields, `evt_valid`, `req_pop` and `err_type` all register on the edge where `req_valid` and `req_ready` are both high. The bench drives its inputs just after a falling edge and records whether that request is accepted. It then compares the outputs at the next falling edge against a model function of the requirement rules. During stalls driven by `evt_ready`, it compares the held outputs every cycle against the values captured when the event was issued.

// File: rtl/l1_split_dispatch.sv
module l1_split_dispatch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              icache_hit,
  input  logic              dcache_hit,
  input  logic              space_avail,
  input  logic [ADDR_W-1:0] victim_addr,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [1:0]        evt_code,
  output logic [ADDR_W-1:0] evt_addr,
  output logic              evt_pop,
  output logic              req_pop,
  output logic              err_type
);

  localparam logic [1:0] EV_LOAD = 2'd0;
  localparam logic [1:0] EV_IFETCH = 2'd1;
  localparam logic [1:0] EV_STORE = 2'd2;
  localparam logic [1:0] EV_REPL = 2'd3;

  logic              is_fetch, bad_type, tgt_hit, oth_hit, accept;
  logic [1:0]        own_evt, nxt_code;
  logic [ADDR_W-1:0] nxt_addr;
  logic              nxt_pop;

  assign is_fetch = (req_type == 3'd1);
  assign bad_type = (req_type > 3'd3);
  assign tgt_hit  = is_fetch ? icache_hit : dcache_hit;
  assign oth_hit  = is_fetch ? dcache_hit : icache_hit;
  assign req_ready = !evt_valid || evt_ready;
  assign accept   = req_valid && req_ready;

  always_comb begin
    unique case (req_type)
      3'd0:    own_evt = EV_LOAD;
      3'd1:    own_evt = EV_IFETCH;
      default: own_evt = EV_STORE;
    endcase
  end

  always_comb begin
    nxt_code = own_evt;
    nxt_addr = req_addr;
    nxt_pop  = 1'b1;
    if (oth_hit) begin
      nxt_code = EV_REPL;
      nxt_pop  = 1'b0;
    end else if (!tgt_hit && !space_avail) begin
      nxt_code = EV_REPL;
      nxt_addr = victim_addr;
      nxt_pop  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_code  <= EV_LOAD;
      evt_addr  <= '0;
      evt_pop   <= 1'b0;
      req_pop   <= 1'b0;
      err_type  <= 1'b0;
    end else begin
      req_pop  <= accept && !bad_type && nxt_pop;
      err_type <= accept && bad_type;
      if (accept) begin
        evt_valid <= !bad_type;
        if (!bad_type) begin
          evt_code <= nxt_code;
          evt_addr <= nxt_addr;
          evt_pop  <= nxt_pop;
        end
      end else if (evt_ready) begin
        evt_valid <= 1'b0;
      end
    end
  end

endmodule

module l1_split_dispatch_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              icache_hit,
  input logic              dcache_hit,
  input logic              space_avail,
  input logic [2:0]        req_type,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [1:0]        evt_code,
  input logic [ADDR_W-1:0] evt_addr,
  input logic              evt_pop,
  input logic              req_pop,
  input logic              err_type
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_code) && $stable(evt_addr) && $stable(evt_pop)); // R10
  AST_STALL_NOREADY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |-> !req_ready); // R10
  AST_REPL_NOPOP: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop |-> evt_valid && evt_code != 2'd3); // R8
  AST_ERR_NOEVT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_type > 3'd3 |=> err_type && !evt_valid); // R11
  AST_WRONG_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_type <= 3'd3 && (req_type == 3'd1 ? dcache_hit : icache_hit)
    |=> evt_valid && evt_code == 2'd3 && !evt_pop); // R3
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_pop && err_type)); // R9
endmodule

bind l1_split_dispatch l1_split_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .icache_hit(icache_hit), .dcache_hit(dcache_hit), .space_avail(space_avail),
  .req_type(req_type), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .evt_code(evt_code), .evt_addr(evt_addr), .evt_pop(evt_pop),
  .req_pop(req_pop), .err_type(err_type));

// File: tb/l1_split_dispatch_bench.sv
module l1_split_dispatch_bench;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, icache_hit = 0, dcache_hit = 0, space_avail = 0;
  logic [2:0] req_type = 0;
  logic [AW-1:0] req_addr = 0, victim_addr = 0, evt_addr;
  logic evt_valid, evt_ready = 1, evt_pop, req_pop, err_type;
  logic [1:0] evt_code;
  int n_cmp = 0, n_bad = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  l1_split_dispatch #(.ADDR_W(AW)) u_l1_split_dispatch (.*);

  function automatic logic [1:0] exp_code(input logic [2:0] t, input logic ih, dh, sp);
    logic th, oh;
    th = (t == 1) ? ih : dh;
    oh = (t == 1) ? dh : ih;
    if (oh) return 2'd3;
    if (!th && !sp) return 2'd3;
    return (t == 0) ? 2'd0 : (t == 1) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [2:0] t, input logic ih, dh, sp,
                                               input logic [AW-1:0] a, v);
    logic th, oh;
    th = (t == 1) ? ih : dh;
    oh = (t == 1) ? dh : ih;
    if (!oh && !th && !sp) return v;
    return a;
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_one(input string req, input logic [2:0] t, input logic ih, dh, sp,
                           input logic [AW-1:0] a, v);
    logic [1:0] ec;
    logic [AW-1:0] ea;
    req_valid = 1; req_type = t; icache_hit = ih; dcache_hit = dh;
    space_avail = sp; req_addr = a; victim_addr = v;
    @(negedge clk);
    req_valid = 0;
    if (t > 3) begin
      chk({req, " R11 err"}, err_type, 1);
      chk({req, " R11 no evt"}, evt_valid, 0);
      return;
    end
    ec = exp_code(t, ih, dh, sp);
    ea = exp_addr(t, ih, dh, sp, a, v);
    chk({req, " R9 valid"}, evt_valid, 1);
    chk({req, " R7 code"}, evt_code, ec);
    chk({req, " R6 addr"}, evt_addr, ea);
    chk({req, " R8 pop"}, req_pop, ec != 3);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 evt_valid", evt_valid, 0);
        chk("R1 req_ready", req_ready, 1);
        drive_one("R2 R7 load", 0, 0, 1, 0, 32'h100, 32'h900);
        drive_one("R2 R7 fetch", 1, 1, 0, 0, 32'h104, 32'h904);
        drive_one("R7 store", 2, 0, 1, 0, 32'h108, 32'h908);
        drive_one("R7 atomic", 3, 0, 0, 1, 32'h10c, 32'h90c);
        drive_one("R3 load in icache", 0, 1, 0, 1, 32'h110, 32'h910);
        drive_one("R3 fetch in dcache", 1, 0, 1, 0, 32'h114, 32'h914);
        drive_one("R4 fetch hit", 1, 1, 0, 0, 32'h118, 32'h918);
        drive_one("R5 store miss space", 2, 0, 0, 1, 32'h11c, 32'h91c);
        drive_one("R6 load full", 0, 0, 0, 0, 32'h120, 32'hAAA0);
        drive_one("R6 fetch full", 1, 0, 0, 0, 32'h124, 32'hBBB0);
        drive_one("R11 bad type", 5, 0, 0, 1, 32'h128, 32'h0);
        // R10 stall
        evt_ready = 0;
        drive_one("R10 stall issue", 2, 0, 1, 0, 32'h200, 32'h0);
        req_valid = 1; req_type = 0; req_addr = 32'h300; space_avail = 1; dcache_hit = 0;
        repeat (3) begin
          @(negedge clk);
          chk("R10 hold code", evt_code, 2);
          chk("R10 hold addr", evt_addr, 32'h200);
          chk("R10 ready low", req_ready, 0);
        end
        evt_ready = 1;
        @(negedge clk);
        chk("R10 next code", evt_code, 0);
        chk("R10 next addr", evt_addr, 32'h300);
        req_valid = 0;
        @(negedge clk);
        chk("R9 idle drop", evt_valid, 0);
        for (int i = 0; i < 400; i++) begin
          logic [2:0] t;
          logic ih, dh;
          t = 3'($urandom(seed) % 4);
          seed = seed + 7;
          ih = 1'($urandom(seed)); dh = 1'($urandom(seed + 1));
          if (ih && dh) dh = 0;
          seed = seed + 3;
          drive_one("random", t, ih, dh, 1'($urandom(seed)), $urandom(seed + 2), $urandom(seed + 5));
          seed = seed + 11;
        end
      end
      begin
        repeat (50000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule